// File: doc/BRIEF.md
# Frequency-Compensated Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in nanoseconds. On every cycle of the reference clock, while the timer is enabled, a 32-bit rate word is added into a 32-bit phase accumulator. Each time that sum overflows, the nanosecond counter moves forward by a programmable tick period. The rate word controls how often overflows occur, so software can trim the clock's average rate in steps far finer than one tick. The nominal rate word is ceil(2^32 × f_nominal / f_reference), where the nominal tick frequency is below the reference frequency. The tick period is 1e9 / f_nominal. A fine adjustment of `ppb` parts per billion rewrites the rate word to nominal ± round(nominal × ppb / 1e9).

The reported time is the counter plus a signed 64-bit offset, taken modulo 2^64. The offset lets software step the clock without touching the counter. The reported time is always visible on a registered 64-bit output. Software also reaches it through a small word-wide register port. Reading the low word freezes the high word, so the pair read back is coherent. The 64-bit counter and the 64-bit offset are each written low word first. The high-word write commits the full value in a single cycle.

Top module: `tod_counter`

## Requirements
- R1: A synchronous active-high reset clears the counter, the offset, the accumulator, the rate word, the control fields, the staged words, `rvalid` and `tod_ns`.
- R2: While enabled, each clock adds `addend` to the accumulator modulo 2^32. The counter gains exactly the tick period on each clock whose addition carries out of bit 31, and it is unchanged on every other clock.
- R3: While the enable bit is clear, the accumulator and the counter both hold their values.
- R4: `tod_ns` equals (counter + offset) mod 2^64, using the values the registers held one clock earlier.
- R5: A read at address 0 returns the low 32 bits of counter+offset in that cycle and captures the high 32 bits in a shadow. A read at address 1 returns that shadow, however many ticks have passed since. Read data and `rvalid` appear on the clock after `rd_en`.
- R6: A write to address 0 only stages the low word, and the counter does not change. A write to address 1 loads {wdata, staged low} into the counter at that clock edge.
- R7: A write to address 2 stages the offset's low word. A write to address 3 commits {wdata, staged low} as the offset. Reads at addresses 2 and 3 return the offset's low and high words.
- R8: Address 4 holds the 32-bit rate word. It reads back as written, and it is used from the clock after the write.
- R9: Address 5 is the control register. Bit 0 is the enable and bits 23:16 are the tick period in ns. All other bits read as zero. Unmapped addresses read as zero.
- R10: A counter load takes priority over a tick in the same cycle, so the loaded value is exact. The accumulator keeps running during the load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register select |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| rvalid | output | 1 | High the cycle after a read |
| tod_ns | output | 64 | Reported time, counter plus offset, registered |

## Verification
Register writes take effect at the clock edge on which they are sampled. Read data and `rvalid` are due one clock after `rd_en`. `tod_ns` reflects the counter and offset one clock after they change, so a committed counter load is first visible on `tod_ns` two clock edges after the write strobe is driven. The bench drives inputs on falling edges and advances its behavioural model on each rising edge. On each falling edge in between, it compares `tod_ns`, `rvalid` and any read data against that model. Directed checks with fixed expected values sample on the falling edge that follows the edge where the result is due, and cover reset, load priority, offset wrap, shadow coherence and control masking.

// File: rtl/tod_pkg.sv
package tod_pkg;
  typedef enum logic [2:0] {
    SEL_TIME_LO = 3'd0,
    SEL_TIME_HI = 3'd1,
    SEL_OFS_LO  = 3'd2,
    SEL_OFS_HI  = 3'd3,
    SEL_RATE    = 3'd4,
    SEL_CTRL    = 3'd5
  } reg_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_PER_LSB = 16;
endpackage

// File: rtl/tod_phase_acc.sv
module tod_phase_acc #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [AW-1:0] addend,
  output logic          carry
);
  logic [AW-1:0] acc;
  logic [AW:0]   sum;

  assign sum   = {1'b0, acc} + {1'b0, addend};
  assign carry = en & sum[AW];

  always_ff @(posedge clk) begin
    if (rst)     acc <= '0;
    else if (en) acc <= sum[AW-1:0];
  end

  AST_ACC_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(acc)); // R3
endmodule

// File: rtl/tod_ns_counter.sv
module tod_ns_counter #(
  parameter int TW = 64,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic [PW-1:0] period,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic [TW-1:0] cnt
);
  localparam int EXT = TW - PW;

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (load) cnt <= load_val;
    else if (step) cnt <= cnt + {{EXT{1'b0}}, period};
  end

  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val))); // R10
  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!load && !step) |=> $stable(cnt)); // R3
endmodule

// File: rtl/tod_regfile.sv
module tod_regfile
  import tod_pkg::*;
#(
  parameter int DW = 32,
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [2:0]      addr,
  input  logic [DW-1:0]   wdata,
  input  logic [2*DW-1:0] report,
  output logic [DW-1:0]   rdata,
  output logic            rvalid,
  output logic [DW-1:0]   addend,
  output logic            enable,
  output logic [PW-1:0]   period,
  output logic [2*DW-1:0] ofs,
  output logic            cnt_load,
  output logic [2*DW-1:0] cnt_load_val
);
  localparam int PAD_HI = DW - CTRL_PER_LSB - PW;
  localparam int PAD_LO = CTRL_PER_LSB - 1;

  reg_sel_e      sel;
  logic [DW-1:0] cnt_lo_stage;
  logic [DW-1:0] ofs_lo_stage;
  logic [DW-1:0] shadow_hi;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] ctrl_view;

  assign sel          = reg_sel_e'(addr);
  assign cnt_load     = wr_en && (sel == SEL_TIME_HI);
  assign cnt_load_val = {wdata, cnt_lo_stage};
  assign ctrl_view    = {{PAD_HI{1'b0}}, period, {PAD_LO{1'b0}}, enable};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_lo_stage <= '0;
      ofs_lo_stage <= '0;
      ofs          <= '0;
      addend       <= '0;
      enable       <= 1'b0;
      period       <= '0;
    end else if (wr_en) begin
      case (sel)
        SEL_TIME_LO: cnt_lo_stage <= wdata;
        SEL_OFS_LO:  ofs_lo_stage <= wdata;
        SEL_OFS_HI:  ofs          <= {wdata, ofs_lo_stage};
        SEL_RATE:    addend       <= wdata;
        SEL_CTRL: begin
          enable <= wdata[CTRL_EN_BIT];
          period <= wdata[CTRL_PER_LSB +: PW];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_TIME_LO: rd_mux = report[DW-1:0];
      SEL_TIME_HI: rd_mux = shadow_hi;
      SEL_OFS_LO:  rd_mux = ofs[DW-1:0];
      SEL_OFS_HI:  rd_mux = ofs[2*DW-1:DW];
      SEL_RATE:    rd_mux = addend;
      SEL_CTRL:    rd_mux = ctrl_view;
      default:     rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_hi <= '0;
      rdata     <= '0;
      rvalid    <= 1'b0;
    end else begin
      rvalid <= rd_en;
      if (rd_en) begin
        rdata <= rd_mux;
        if (sel == SEL_TIME_LO) shadow_hi <= report[2*DW-1:DW];
      end
    end
  end

  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && (addr == 3'd0)) |=> $stable(shadow_hi)); // R5
  AST_RVALID: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rvalid); // R5
  AST_OFS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && (addr == 3'd3)) |=> $stable(ofs)); // R7
endmodule

// File: rtl/tod_counter.sv
module tod_counter #(
  parameter int DW = 32,
  parameter int PW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [2:0]      addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic            rvalid,
  output logic [2*DW-1:0] tod_ns
);
  localparam int TW = 2 * DW;

  logic [DW-1:0] addend;
  logic          enable;
  logic [PW-1:0] period;
  logic [TW-1:0] ofs;
  logic [TW-1:0] cnt;
  logic [TW-1:0] report;
  logic          cnt_load;
  logic [TW-1:0] cnt_load_val;
  logic          carry;

  assign report = cnt + ofs;

  tod_regfile #(.DW(DW), .PW(PW)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .report(report), .rdata(rdata), .rvalid(rvalid),
    .addend(addend), .enable(enable), .period(period), .ofs(ofs),
    .cnt_load(cnt_load), .cnt_load_val(cnt_load_val)
  );

  tod_phase_acc #(.AW(DW)) u_acc (
    .clk(clk), .rst(rst), .en(enable), .addend(addend), .carry(carry)
  );

  tod_ns_counter #(.TW(TW), .PW(PW)) u_cnt (
    .clk(clk), .rst(rst), .step(carry), .period(period),
    .load(cnt_load), .load_val(cnt_load_val), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) tod_ns <= '0;
    else     tod_ns <= report;
  end

  AST_TOD_FOLLOWS_LOAD: assert property (@(posedge clk) disable iff (rst)
    cnt_load |=> ##1 (tod_ns == $past(cnt_load_val, 2) + $past(ofs))); // R4
endmodule

// File: tb/sim_tod_counter.sv
module sim_tod_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rvalid;
  logic [63:0] tod_ns;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  tod_counter u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .tod_ns(tod_ns)
  );

  // behavioural reference model
  longint unsigned m_cnt, m_ofs, m_tod, m_acc;
  logic [31:0] m_add, m_clo, m_olo, m_shadow, m_rdata;
  logic [7:0]  m_per;
  logic        m_en, m_rvalid;

  always @(posedge clk) begin
    longint unsigned rep, s;
    bit carry;
    if (rst) begin
      m_cnt = 0; m_ofs = 0; m_tod = 0; m_acc = 0; m_add = 0; m_clo = 0;
      m_olo = 0; m_shadow = 0; m_rdata = 0; m_per = 0; m_en = 0; m_rvalid = 0;
    end else begin
      rep = m_cnt + m_ofs;
      m_tod = rep;
      carry = 0;
      if (m_en) begin
        s = m_acc + longint'(m_add);
        carry = s[32];
        m_acc = s & 64'hFFFF_FFFF;
      end
      m_rvalid = rd_en;
      if (rd_en) begin
        case (addr)
          3'd0: begin m_rdata = rep[31:0]; m_shadow = rep[63:32]; end
          3'd1: m_rdata = m_shadow;
          3'd2: m_rdata = m_ofs[31:0];
          3'd3: m_rdata = m_ofs[63:32];
          3'd4: m_rdata = m_add;
          3'd5: m_rdata = {8'h00, m_per, 15'h0000, m_en};
          default: m_rdata = 0;
        endcase
      end
      if (wr_en && addr == 3'd1) m_cnt = {wdata, m_clo};
      else if (carry) m_cnt = m_cnt + longint'(m_per);
      if (wr_en) begin
        case (addr)
          3'd0: m_clo = wdata;
          3'd2: m_olo = wdata;
          3'd3: m_ofs = {wdata, m_olo};
          3'd4: m_add = wdata;
          3'd5: begin m_en = wdata[0]; m_per = wdata[23:16]; end
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      chk("R4 tod_ns", tod_ns, m_tod);
      chk("R5 rvalid", {63'd0, rvalid}, {63'd0, m_rvalid});
      if (rvalid) chk("R5 rdata", {32'd0, rdata}, {32'd0, m_rdata});
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d, lo;
    logic [63:0] saved;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R1: reset state
    chk("R1 tod", tod_ns, 64'd0);
    rd(3'd5, d); chk("R1 ctrl", {32'd0, d}, 64'd0);
    rd(3'd4, d); chk("R1 rate", {32'd0, d}, 64'd0);
    // R9: control masking and unmapped address
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); chk("R9 ctrl mask", {32'd0, d}, 64'h00FF_0001);
    wr(3'd5, 32'h0000_0000);
    rd(3'd6, d); chk("R9 unmapped", {32'd0, d}, 64'd0);
    // R6: low write alone does not move the counter
    wr(3'd0, 32'hFFFF_FFF0);
    @(negedge clk); chk("R6 lo only", tod_ns, 64'd0);
    wr(3'd1, 32'h0000_0001);
    @(negedge clk); chk("R6 load", tod_ns, 64'h0000_0001_FFFF_FFF0);
    // R7: offset, positive then negative
    wr(3'd2, 32'h0000_0020); wr(3'd3, 32'h0);
    @(negedge clk); chk("R7 ofs pos", tod_ns, 64'h0000_0002_0000_0010);
    wr(3'd2, 32'hFFFF_FFF0); wr(3'd3, 32'hFFFF_FFFF);
    @(negedge clk); chk("R7 ofs neg", tod_ns, 64'h0000_0001_FFFF_FFE0);
    rd(3'd3, d); chk("R7 ofs hi read", {32'd0, d}, 64'h0000_0000_FFFF_FFFF);
    rd(3'd0, d); chk("R5 lo read", {32'd0, d}, 64'h0000_0000_FFFF_FFE0);
    rd(3'd1, d); chk("R5 hi read", {32'd0, d}, 64'h0000_0000_0000_0001);
    // R8: rate word readback
    wr(3'd4, 32'h4000_0000);
    rd(3'd4, d); chk("R8 rate", {32'd0, d}, 64'h0000_0000_4000_0000);
    // R2: carry every fourth enabled clock, period 10
    wr(3'd5, 32'h000A_0001);
    repeat (40) @(negedge clk);
    chk("R2 advance", tod_ns, m_tod);
    // R5: shadow stays coherent while ticking
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd0, lo);
    saved = m_tod;
    repeat (30) @(negedge clk);
    rd(3'd1, d); chk("R5 shadow", {32'd0, d}, {32'd0, m_shadow});
    chk("R5 shadow moved", {63'd0, (tod_ns != saved)}, 64'd1);
    // R10: load while carrying almost every cycle
    wr(3'd0, 32'h1234_5678);
    wr(3'd1, 32'h0000_00AB);
    @(negedge clk); chk("R10 exact load", tod_ns, 64'h0000_00AB_1234_5678 + m_ofs);
    // R3: disable freezes everything
    wr(3'd5, 32'h000A_0000);
    @(negedge clk); saved = tod_ns;
    repeat (25) @(negedge clk);
    chk("R3 hold", tod_ns, saved);
    // R2: odd rate resumes from held phase
    wr(3'd4, 32'h2345_6789);
    wr(3'd5, 32'h0007_0001);
    repeat (60) @(negedge clk);
    chk("R2 odd rate", tod_ns, m_tod);
    // R1: reset again mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 reset mid", tod_ns, 64'd0);
    repeat (5) @(negedge clk);
    chk("R1 idle", tod_ns, 64'd0);
    finish_run();
  end
endmodule